// File: doc/BRIEF.md
# PLL Switchover Sequencer

This block moves one clock domain between a PLL output and a plain divided source, in an order that never leaves the domain without a clean clock. A request names the target mode (PLL or divided source), the divider word for the source slot, the packed PLL coefficients, the target frequency in kHz and whether the domain is the core domain. The sequencer then issues an ordered series of masked register writes and reads on a simple bus master port. The control, coefficient and source-selection registers it writes live in a neighbouring clock generator.

In PLL mode the domain is first parked on an alternate source with the PLL bypassed. The reference source and coefficients are then programmed, the PLL is started, and the lock flag is polled. On lock the output switches over to the PLL and the alternate source is released. If lock never comes, the PLL start is undone and the domain stays on the alternate source. In divided mode the alternate source is programmed, the PLL is bypassed, and after a settle time the PLL and the reference source are shut off. For the core domain a memory-timing delay is derived from the frequency. It is written before the switch when it grows and after the switch when it shrinks.

Top module: `pllSwitchSeq`

## Requirements
- R1: After reset `busy`, `busReq` and `done` are low. A request is taken only when `reqValid` is high while idle. A `reqValid` pulse while busy starts nothing and issues no extra bus transfer.
- R2: A bus transfer holds `busReq` and all its fields steady until the cycle `busAck` is high. A write applies `reg = (reg & ~busMask) | (busWdata & busMask)`, and a read has `busWe` low.
- R3: In PLL mode the control register is read first. If its bypass bit 3 is clear, the alternate source gets mask 0x101 value 0x101, then control gets mask 0x8 value 0x8, then the bus stays quiet for exactly SETTLE_CYCLES cycles. If bit 3 is already set, these three steps are skipped.
- R4: The reference source is written with mask 0x003F3141 and value 0x101 OR the divider word. The coefficient register is then written in full with P in bits 21:16, N in bits 15:8 and M in bits 7:0.
- R5: The PLL is started by writing control with mask 0x15 value 0x15, then mask 0x10 value 0.
- R6: Control is then read repeatedly until bit 17 (lock) reads 1. Control then gets mask 0x10 value 0x10 and mask 0x8 value 0. After that the alternate source gets mask 0x100 value 0, then mask 0x1 value 0.
- R7: If a lock read finds bit 17 clear once LOCK_TIMEOUT_CYCLES have elapsed since polling began, control gets mask 0x10 value 0x10. The reference source then gets mask 0x101 value 0, bypass bit 3 stays set, and `timedOut` is high with `done`.
- R8: In divided mode the alternate source gets mask 0x003F3141 and value 0x101 OR the divider word. Control then gets mask 0x18 value 0x18, the bus stays quiet for exactly SETTLE_CYCLES cycles, and control gets mask 0x1 value 0. Finally the reference source gets mask 0x100 value 0, then mask 0x1 value 0.
- R9: The core memory delay is max((kHz + 7566) / 15133, 18), using integer division, and is written to the whole delay register.
- R10: For a core request the delay register is read before anything else. The new delay is written before the switch if it is larger than the current value, after the switch if it is smaller, and not at all if it is equal. A non-core request never touches the delay register.
- R11: `busy` is high from the cycle after a request is taken until the one-cycle `done` pulse. `timedOut` is low with `done` when lock was reached or no PLL was asked for.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when idle |
| reqUsePll | input | 1 | 1: move to PLL, 0: move to divided source |
| reqCore | input | 1 | Domain carries the memory delay update |
| reqDiv | input | 32 | Divider word for the source slot |
| reqP | input | 6 | PLL post divider |
| reqN | input | 8 | PLL feedback multiplier |
| reqM | input | 8 | PLL reference divider |
| reqKhz | input | KHZ_W | Target frequency in kHz |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| timedOut | output | 1 | Lock wait expired, valid with done |
| busReq | output | 1 | Bus transfer request |
| busWe | output | 1 | 1 write (masked), 0 read |
| busAddr | output | ADDR_W | Register address |
| busMask | output | 32 | Write bit mask |
| busWdata | output | 32 | Write data |
| busAck | input | 1 | Transfer complete |
| busRdata | input | 32 | Read data, valid with busAck |

## Verification
The bench aims at the bypass-already-set shortcut, the exact length of the two quiet settle windows, a lock that arrives only after several polls, and a lock that never arrives. A design that always re-parks the clock, waits one cycle too few, or switches to the PLL without lock would send a wrong or missing transfer or a wrong gap count. It also covers the three directions of the memory delay (grow, shrink, equal) and the floor of 18. A misordered delay write would land on the wrong side of the switch, and a missing equality check would produce an extra write. A request pulse while busy is injected, and any second sequence would show up as unexpected transfers.

// File: rtl/pllSwitchPkg.sv
package pllSwitchPkg;

  typedef enum logic [4:0] {
    S_IDLE, S_START, S_MEM_RD, S_MEM_PRE,
    S_CTL_RD, S_ALT_ON, S_BYP_ON, S_BYP_WAIT,
    S_REF_PROG, S_COEF_WR, S_PLL_EN, S_PLL_RUN, S_LOCK_RD,
    S_LOCK_END, S_BYP_OFF, S_ALT_OFF8, S_ALT_OFF0,
    S_FAIL_B4, S_FAIL_REF,
    S_NP_ALT, S_NP_BYP, S_NP_WAIT, S_NP_PLLOFF, S_NP_REF8, S_NP_REF0,
    S_MEM_POST, S_FIN
  } stepE;

  typedef struct packed {
    stepE op;
    logic busGo;
    logic loadReq;
    logic timerClr;
    logic captureMem;
    logic setFail;
  } ctrlStrobeT;

  typedef struct packed {
    logic settleDone;
    logic lockExpired;
    logic rdBypass;
    logic rdLock;
    logic memLower;
    logic memHigher;
    logic usePll;
    logic isCore;
  } dpStatusT;

  localparam int DATA_W = 32;
  localparam int BYPASS_BIT = 3;
  localparam int LOCK_BIT = 17;
  localparam logic [31:0] SRC_FIELD_MASK = 32'h003F_3141;
  localparam logic [31:0] SRC_ON = 32'h0000_0101;
  localparam int DLY_BIAS = 7566;
  localparam int DLY_STEP = 15133;
  localparam int DLY_FLOOR = 18;

endpackage

// File: rtl/pllSwitchDp.sv
module pllSwitchDp
  import pllSwitchPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int KHZ_W = 24,
  parameter int DLY_W = 16,
  parameter int SETTLE_CYCLES = 5000,
  parameter int LOCK_TIMEOUT_CYCLES = 500000000,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h100,
  parameter logic [ADDR_W-1:0] COEF_ADDR = 'h104,
  parameter logic [ADDR_W-1:0] REF_ADDR = 'h200,
  parameter logic [ADDR_W-1:0] ALT_ADDR = 'h204,
  parameter logic [ADDR_W-1:0] MEM_ADDR = 'h300
) (
  input  logic clk,
  input  logic rstN,
  input  ctrlStrobeT strobe,
  output dpStatusT status,
  input  logic reqUsePll,
  input  logic reqCore,
  input  logic [DATA_W-1:0] reqDiv,
  input  logic [5:0] reqP,
  input  logic [7:0] reqN,
  input  logic [7:0] reqM,
  input  logic [KHZ_W-1:0] reqKhz,
  input  logic [DATA_W-1:0] busRdata,
  output logic timedOut,
  output logic busReq,
  output logic busWe,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busMask,
  output logic [DATA_W-1:0] busWdata
);

  localparam int CNT_MAX = (SETTLE_CYCLES > LOCK_TIMEOUT_CYCLES) ? SETTLE_CYCLES : LOCK_TIMEOUT_CYCLES;
  localparam int CNT_W = $clog2(CNT_MAX + 2);
  localparam int SUM_W = KHZ_W + 1;

  logic usePllQ, isCoreQ, failQ;
  logic [DATA_W-1:0] divQ, memCur;
  logic [21:0] coefQ;
  logic [DLY_W-1:0] dlyTarget, dlyCalc;
  logic [CNT_W-1:0] cnt;
  logic [SUM_W-1:0] khzSum, quo;

  // delay = max((kHz + bias) / step, floor), evaluated once at accept
  always_comb begin
    khzSum = {1'b0, reqKhz} + SUM_W'(DLY_BIAS);
    quo = khzSum / SUM_W'(DLY_STEP);
    dlyCalc = (quo < SUM_W'(DLY_FLOOR)) ? DLY_W'(DLY_FLOOR) : DLY_W'(quo);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      usePllQ <= 1'b0;
      isCoreQ <= 1'b0;
      failQ <= 1'b0;
      divQ <= '0;
      coefQ <= '0;
      dlyTarget <= '0;
      memCur <= '0;
      cnt <= '0;
    end else begin
      if (strobe.loadReq) begin
        usePllQ <= reqUsePll;
        isCoreQ <= reqCore;
        divQ <= reqDiv;
        coefQ <= {reqP, reqN, reqM};
        dlyTarget <= dlyCalc;
        failQ <= 1'b0;
      end
      if (strobe.setFail) failQ <= 1'b1;
      if (strobe.captureMem) memCur <= busRdata;
      if (strobe.timerClr) cnt <= '0;
      else if (cnt != '1) cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    status.settleDone = (cnt == CNT_W'(SETTLE_CYCLES - 1));
    status.lockExpired = (cnt >= CNT_W'(LOCK_TIMEOUT_CYCLES));
    status.rdBypass = busRdata[BYPASS_BIT];
    status.rdLock = busRdata[LOCK_BIT];
    status.memLower = memCur < DATA_W'(dlyTarget);
    status.memHigher = memCur > DATA_W'(dlyTarget);
    status.usePll = usePllQ;
    status.isCore = isCoreQ;
  end

  assign timedOut = failQ;
  assign busReq = strobe.busGo;

  always_comb begin
    busWe = 1'b1;
    busAddr = CTRL_ADDR;
    busMask = '0;
    busWdata = '0;
    unique case (strobe.op)
      S_MEM_RD: begin busWe = 1'b0; busAddr = MEM_ADDR; end
      S_MEM_PRE, S_MEM_POST: begin
        busAddr = MEM_ADDR; busMask = '1; busWdata = DATA_W'(dlyTarget);
      end
      S_CTL_RD, S_LOCK_RD: busWe = 1'b0;
      S_ALT_ON: begin busAddr = ALT_ADDR; busMask = SRC_ON; busWdata = SRC_ON; end
      S_BYP_ON: begin busMask = 32'h8; busWdata = 32'h8; end
      S_REF_PROG: begin busAddr = REF_ADDR; busMask = SRC_FIELD_MASK; busWdata = SRC_ON | divQ; end
      S_COEF_WR: begin busAddr = COEF_ADDR; busMask = '1; busWdata = {10'b0, coefQ}; end
      S_PLL_EN: begin busMask = 32'h15; busWdata = 32'h15; end
      S_PLL_RUN: busMask = 32'h10;
      S_LOCK_END, S_FAIL_B4: begin busMask = 32'h10; busWdata = 32'h10; end
      S_BYP_OFF: busMask = 32'h8;
      S_ALT_OFF8: begin busAddr = ALT_ADDR; busMask = 32'h100; end
      S_ALT_OFF0: begin busAddr = ALT_ADDR; busMask = 32'h1; end
      S_FAIL_REF: begin busAddr = REF_ADDR; busMask = SRC_ON; end
      S_NP_ALT: begin busAddr = ALT_ADDR; busMask = SRC_FIELD_MASK; busWdata = SRC_ON | divQ; end
      S_NP_BYP: begin busMask = 32'h18; busWdata = 32'h18; end
      S_NP_PLLOFF: busMask = 32'h1;
      S_NP_REF8: begin busAddr = REF_ADDR; busMask = 32'h100; end
      S_NP_REF0: begin busAddr = REF_ADDR; busMask = 32'h1; end
      default: ;
    endcase
  end

endmodule

// File: rtl/pllSwitchCtrl.sv
module pllSwitchCtrl
  import pllSwitchPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic busAck,
  input  dpStatusT status,
  output ctrlStrobeT strobe,
  output logic busy,
  output logic done
);

  stepE step, nextStep, pathStart, pathEnd;

  always_ff @(posedge clk) begin
    if (!rstN) step <= S_IDLE;
    else step <= nextStep;
  end

  assign pathStart = status.usePll ? S_CTL_RD : S_NP_ALT;
  assign pathEnd = status.isCore ? S_MEM_POST : S_FIN;

  always_comb begin
    strobe = '0;
    strobe.op = step;
    nextStep = step;
    unique case (step)
      S_IDLE: if (reqValid) begin strobe.loadReq = 1'b1; nextStep = S_START; end
      S_START: nextStep = status.isCore ? S_MEM_RD : pathStart;
      S_MEM_RD: begin
        strobe.busGo = 1'b1;
        if (busAck) begin strobe.captureMem = 1'b1; nextStep = S_MEM_PRE; end
      end
      S_MEM_PRE: begin
        if (status.memLower) begin
          strobe.busGo = 1'b1;
          if (busAck) nextStep = pathStart;
        end else nextStep = pathStart;
      end
      S_CTL_RD: begin
        strobe.busGo = 1'b1;
        if (busAck) nextStep = status.rdBypass ? S_REF_PROG : S_ALT_ON;
      end
      S_ALT_ON: begin strobe.busGo = 1'b1; if (busAck) nextStep = S_BYP_ON; end
      S_BYP_ON: begin
        strobe.busGo = 1'b1;
        if (busAck) begin strobe.timerClr = 1'b1; nextStep = S_BYP_WAIT; end
      end
      S_BYP_WAIT: if (status.settleDone) nextStep = S_REF_PROG;
      S_REF_PROG: begin strobe.busGo = 1'b1; if (busAck) nextStep = S_COEF_WR; end
      S_COEF_WR: begin strobe.busGo = 1'b1; if (busAck) nextStep = S_PLL_EN; end
      S_PLL_EN: begin strobe.busGo = 1'b1; if (busAck) nextStep = S_PLL_RUN; end
      S_PLL_RUN: begin
        strobe.busGo = 1'b1;
        if (busAck) begin strobe.timerClr = 1'b1; nextStep = S_LOCK_RD; end
      end
      S_LOCK_RD: begin
        strobe.busGo = 1'b1;
        if (busAck) begin
          if (status.rdLock) nextStep = S_LOCK_END;
          else if (status.lockExpired) begin strobe.setFail = 1'b1; nextStep = S_FAIL_B4; end
        end
      end
      S_LOCK_END: begin strobe.busGo = 1'b1; if (busAck) nextStep = S_BYP_OFF; end
      S_BYP_OFF: begin strobe.busGo = 1'b1; if (busAck) nextStep = S_ALT_OFF8; end
      S_ALT_OFF8: begin strobe.busGo = 1'b1; if (busAck) nextStep = S_ALT_OFF0; end
      S_ALT_OFF0: begin strobe.busGo = 1'b1; if (busAck) nextStep = pathEnd; end
      S_FAIL_B4: begin strobe.busGo = 1'b1; if (busAck) nextStep = S_FAIL_REF; end
      S_FAIL_REF: begin strobe.busGo = 1'b1; if (busAck) nextStep = pathEnd; end
      S_NP_ALT: begin strobe.busGo = 1'b1; if (busAck) nextStep = S_NP_BYP; end
      S_NP_BYP: begin
        strobe.busGo = 1'b1;
        if (busAck) begin strobe.timerClr = 1'b1; nextStep = S_NP_WAIT; end
      end
      S_NP_WAIT: if (status.settleDone) nextStep = S_NP_PLLOFF;
      S_NP_PLLOFF: begin strobe.busGo = 1'b1; if (busAck) nextStep = S_NP_REF8; end
      S_NP_REF8: begin strobe.busGo = 1'b1; if (busAck) nextStep = S_NP_REF0; end
      S_NP_REF0: begin strobe.busGo = 1'b1; if (busAck) nextStep = pathEnd; end
      S_MEM_POST: begin
        if (status.memHigher) begin
          strobe.busGo = 1'b1;
          if (busAck) nextStep = S_FIN;
        end else nextStep = S_FIN;
      end
      S_FIN: nextStep = S_IDLE;
      default: nextStep = S_IDLE;
    endcase
  end

  assign busy = (step != S_IDLE);
  assign done = (step == S_FIN);

endmodule

// File: rtl/pllSwitchSeq.sv
module pllSwitchSeq
  import pllSwitchPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int KHZ_W = 24,
  parameter int DLY_W = 16,
  parameter int SETTLE_CYCLES = 5000,
  parameter int LOCK_TIMEOUT_CYCLES = 500000000,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h100,
  parameter logic [ADDR_W-1:0] COEF_ADDR = 'h104,
  parameter logic [ADDR_W-1:0] REF_ADDR = 'h200,
  parameter logic [ADDR_W-1:0] ALT_ADDR = 'h204,
  parameter logic [ADDR_W-1:0] MEM_ADDR = 'h300
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic reqUsePll,
  input  logic reqCore,
  input  logic [31:0] reqDiv,
  input  logic [5:0] reqP,
  input  logic [7:0] reqN,
  input  logic [7:0] reqM,
  input  logic [KHZ_W-1:0] reqKhz,
  output logic busy,
  output logic done,
  output logic timedOut,
  output logic busReq,
  output logic busWe,
  output logic [ADDR_W-1:0] busAddr,
  output logic [31:0] busMask,
  output logic [31:0] busWdata,
  input  logic busAck,
  input  logic [31:0] busRdata
);

  ctrlStrobeT strobe;
  dpStatusT status;

  pllSwitchCtrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .busAck(busAck),
    .status(status), .strobe(strobe), .busy(busy), .done(done)
  );

  pllSwitchDp #(
    .ADDR_W(ADDR_W), .KHZ_W(KHZ_W), .DLY_W(DLY_W),
    .SETTLE_CYCLES(SETTLE_CYCLES), .LOCK_TIMEOUT_CYCLES(LOCK_TIMEOUT_CYCLES),
    .CTRL_ADDR(CTRL_ADDR), .COEF_ADDR(COEF_ADDR), .REF_ADDR(REF_ADDR),
    .ALT_ADDR(ALT_ADDR), .MEM_ADDR(MEM_ADDR)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .status(status),
    .reqUsePll(reqUsePll), .reqCore(reqCore), .reqDiv(reqDiv),
    .reqP(reqP), .reqN(reqN), .reqM(reqM), .reqKhz(reqKhz),
    .busRdata(busRdata), .timedOut(timedOut),
    .busReq(busReq), .busWe(busWe), .busAddr(busAddr),
    .busMask(busMask), .busWdata(busWdata)
  );

endmodule

// File: rtl/pllSwitchChecker.sv
module pllSwitchChecker #(
  parameter int ADDR_W = 24
) (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic busy,
  input logic done,
  input logic busReq,
  input logic busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0] busMask,
  input logic [31:0] busWdata,
  input logic busAck
);

  // R2: a pending transfer keeps every field until acknowledged
  a_r2_hold_until_ack: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(busWe) && $stable(busAddr)
                          && $stable(busMask) && $stable(busWdata));

  // R1: no bus activity and no completion while idle
  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !busReq && !done);

  // R1: a sequence starts only from a request
  a_r1_start_on_request: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid));

  // R11: completion is a single-cycle pulse that returns to idle
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy);

endmodule

bind pllSwitchSeq pllSwitchChecker #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .busy(busy), .done(done),
  .busReq(busReq), .busWe(busWe), .busAddr(busAddr), .busMask(busMask),
  .busWdata(busWdata), .busAck(busAck)
);

// File: tb/pllSwitchSeq_test.sv
`timescale 1ns/1ps
module pllSwitchSeq_test;

  localparam int SETTLE = 12;
  localparam int LOCK_TO = 40;
  localparam logic [23:0] A_CTRL = 24'h100, A_COEF = 24'h104, A_REF = 24'h200,
                          A_ALT = 24'h204, A_MEM = 24'h300;

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqUsePll = 0, reqCore = 0;
  logic [31:0] reqDiv = 0;
  logic [5:0] reqP = 0;
  logic [7:0] reqN = 0, reqM = 0;
  logic [23:0] reqKhz = 0;
  logic busy, done, timedOut, busReq, busWe;
  logic [23:0] busAddr;
  logic [31:0] busMask, busWdata;
  logic busAck = 0;
  logic [31:0] busRdata = 0;

  always #2 clk = ~clk;

  pllSwitchSeq #(.SETTLE_CYCLES(SETTLE), .LOCK_TIMEOUT_CYCLES(LOCK_TO)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqUsePll(reqUsePll),
    .reqCore(reqCore), .reqDiv(reqDiv), .reqP(reqP), .reqN(reqN), .reqM(reqM),
    .reqKhz(reqKhz), .busy(busy), .done(done), .timedOut(timedOut),
    .busReq(busReq), .busWe(busWe), .busAddr(busAddr), .busMask(busMask),
    .busWdata(busWdata), .busAck(busAck), .busRdata(busRdata));

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, string msg);
    nChecks++;
    if (!ok) begin nFail++; $display("FAIL %s: %s", req, msg); end
  endtask

  // register target model
  logic [31:0] rCtrl, rCoef, rRef, rAlt, rMem;
  int lockReads = 0, lockNeed = 0;

  function automatic logic [31:0] mrg(logic [31:0] o, logic [31:0] m, logic [31:0] v);
    return (o & ~m) | (v & m);
  endfunction

  always @(posedge clk) begin
    if (!rstN) busAck <= 0;
    else if (busReq && !busAck) begin
      busAck <= 1;
      if (busWe) begin
        case (busAddr)
          A_CTRL: begin rCtrl = mrg(rCtrl, busMask, busWdata); lockReads = 0; end
          A_COEF: rCoef = mrg(rCoef, busMask, busWdata);
          A_REF: rRef = mrg(rRef, busMask, busWdata);
          A_ALT: rAlt = mrg(rAlt, busMask, busWdata);
          A_MEM: rMem = mrg(rMem, busMask, busWdata);
          default: ;
        endcase
      end else begin
        case (busAddr)
          A_CTRL: begin
            busRdata <= rCtrl | ((lockReads >= lockNeed) ? 32'h0002_0000 : 32'h0);
            lockReads++;
          end
          A_MEM: busRdata <= rMem;
          default: busRdata <= 32'h0;
        endcase
      end
    end else busAck <= 0;
  end

  // scoreboard
  typedef struct {
    bit poll; bit we; logic [23:0] addr; logic [31:0] mask; logic [31:0] val;
    int gap; string tag;
  } expT;
  expT q[$];
  int gap = 0, pollCnt = 0;
  bit handled;
  expT e;

  task automatic expWr(logic [23:0] a, logic [31:0] m, logic [31:0] v, int g, string t);
    expT x; x.poll = 0; x.we = 1; x.addr = a; x.mask = m; x.val = v; x.gap = g; x.tag = t;
    q.push_back(x);
  endtask
  task automatic expRd(logic [23:0] a, int g, string t);
    expT x; x.poll = 0; x.we = 0; x.addr = a; x.mask = 0; x.val = 0; x.gap = g; x.tag = t;
    q.push_back(x);
  endtask
  task automatic expPoll();
    expT x; x.poll = 1; x.we = 0; x.addr = A_CTRL; x.mask = 0; x.val = 0; x.gap = -1; x.tag = "R6";
    q.push_back(x);
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (busAck) begin
        handled = 0;
        if (q.size() > 0 && q[0].poll) begin
          if (!busWe && busAddr == A_CTRL) begin pollCnt++; handled = 1; end
          else begin
            check(pollCnt > 0, "R6", $sformatf("lock polls got %0d expected >=1", pollCnt));
            void'(q.pop_front());
            pollCnt = 0;
          end
        end
        if (!handled) begin
          if (q.size() == 0)
            check(0, "R1", $sformatf("unexpected transfer got we=%0d addr=%h mask=%h data=%h expected none",
                                     busWe, busAddr, busMask, busWdata));
          else begin
            e = q.pop_front();
            check(busWe == e.we && busAddr == e.addr && (!e.we || busMask == e.mask) &&
                  (!e.we || (busWdata & busMask) == (e.val & e.mask)) && (e.gap < 0 || gap == e.gap),
                  e.tag, $sformatf("got we=%0d addr=%h mask=%h data=%h gap=%0d expected we=%0d addr=%h mask=%h data=%h gap=%0d",
                                   busWe, busAddr, busMask, busWdata & busMask, gap,
                                   e.we, e.addr, e.mask, e.val & e.mask, e.gap));
          end
        end
        gap = 0;
      end else if (!busy) gap = 0;
      else if (!busReq) gap++;
    end
  end

  function automatic logic [31:0] dly(int khz);
    int d = (khz + 7566) / 15133;
    return (d < 18) ? 32'd18 : d;
  endfunction

  task automatic expPllPath(bit byp, logic [31:0] div, logic [31:0] coef, bit lockOk, int g0);
    expRd(A_CTRL, g0, "R3");
    if (!byp) begin
      expWr(A_ALT, 32'h101, 32'h101, 0, "R3");
      expWr(A_CTRL, 32'h8, 32'h8, 0, "R3");
    end
    expWr(A_REF, 32'h003F3141, 32'h101 | div, byp ? 0 : SETTLE, "R4");
    expWr(A_COEF, 32'hFFFFFFFF, coef, 0, "R4");
    expWr(A_CTRL, 32'h15, 32'h15, 0, "R5");
    expWr(A_CTRL, 32'h10, 32'h0, 0, "R5");
    expPoll();
    if (lockOk) begin
      expWr(A_CTRL, 32'h10, 32'h10, -1, "R6");
      expWr(A_CTRL, 32'h8, 32'h0, 0, "R6");
      expWr(A_ALT, 32'h100, 32'h0, 0, "R6");
      expWr(A_ALT, 32'h1, 32'h0, 0, "R6");
    end else begin
      expWr(A_CTRL, 32'h10, 32'h10, -1, "R7");
      expWr(A_REF, 32'h101, 32'h0, 0, "R7");
    end
  endtask

  task automatic expNpPath(logic [31:0] div, int g0);
    expWr(A_ALT, 32'h003F3141, 32'h101 | div, g0, "R8");
    expWr(A_CTRL, 32'h18, 32'h18, 0, "R8");
    expWr(A_CTRL, 32'h1, 32'h0, SETTLE, "R8");
    expWr(A_REF, 32'h100, 32'h0, 0, "R8");
    expWr(A_REF, 32'h1, 32'h0, 0, "R8");
  endtask

  task automatic issue(bit pll, bit core, logic [31:0] div, logic [5:0] p,
                       logic [7:0] n, logic [7:0] m, int khz);
    @(negedge clk);
    reqUsePll = pll; reqCore = core; reqDiv = div; reqP = p; reqN = n; reqM = m;
    reqKhz = khz[23:0]; reqValid = 1;
    @(negedge clk);
    reqValid = 0;
    check(busy == 1, "R11", $sformatf("busy after accept got %0d expected 1", busy));
  endtask

  task automatic finish(bit expFail, string tag);
    int k = 0;
    while (!done && k < 3000) begin @(negedge clk); k++; end
    check(done == 1, "R11", $sformatf("done got %0d expected 1 (%s)", done, tag));
    check(timedOut == expFail, expFail ? "R7" : "R11",
          $sformatf("timedOut got %0d expected %0d (%s)", timedOut, expFail, tag));
    repeat (3) @(negedge clk);
    check(q.size() == 0 && !busy, "R1",
          $sformatf("pending items got %0d busy=%0d expected 0 busy=0 (%s)", q.size(), busy, tag));
  endtask

  initial begin
    rCtrl = 0; rCoef = 0; rRef = 0; rAlt = 0; rMem = 0;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(!busy && !busReq && !done, "R1",
          $sformatf("reset state got busy=%0d req=%0d done=%0d expected 0 0 0", busy, busReq, done));

    // PLL, not bypassed, lock after several polls
    rCtrl = 0; rAlt = 0; rRef = 0; lockNeed = 3;
    expPllPath(0, 32'h0005_3000, {10'b0, 6'd2, 8'd40, 8'd3}, 1, 1);
    issue(1, 0, 32'h0005_3000, 6'd2, 8'd40, 8'd3, 400000);
    finish(0, "pll lock");
    check(rCoef == 32'h0002_2803, "R4", $sformatf("coef got %h expected %h", rCoef, 32'h0002_2803));
    check(rCtrl[3] == 0 && rCtrl[4] == 1 && rCtrl[0] == 1, "R6", $sformatf("ctrl got %h expected bit3=0 bit4=1 bit0=1", rCtrl));
    check(rAlt[8] == 0 && rAlt[0] == 0 && rRef == 32'h0005_3101, "R6",
          $sformatf("alt=%h ref=%h expected alt off ref=00053101", rAlt, rRef));

    // PLL, already bypassed, immediate lock
    rCtrl = 32'h8; lockNeed = 0;
    expPllPath(1, 32'h0001_0040, {10'b0, 6'd1, 8'd20, 8'd1}, 1, 1);
    issue(1, 0, 32'h0001_0040, 6'd1, 8'd20, 8'd1, 300000);
    finish(0, "pll bypassed");

    // PLL, lock never comes
    rCtrl = 0; rAlt = 0; rRef = 0; lockNeed = 1000;
    expPllPath(0, 32'h0, {10'b0, 6'd1, 8'd30, 8'd2}, 0, 1);
    issue(1, 0, 32'h0, 6'd1, 8'd30, 8'd2, 600000);
    finish(1, "timeout");
    check(rCtrl[3] == 1 && rCtrl[4] == 1, "R7", $sformatf("ctrl got %h expected bit3=1 bit4=1", rCtrl));
    check(rRef[8] == 0 && rRef[0] == 0 && rAlt[8] == 1, "R7",
          $sformatf("ref=%h alt=%h expected ref off alt on", rRef, rAlt));

    // divided source, non-core, plus a request pulse while busy
    rCtrl = 32'h11; rRef = 32'h101;
    expNpPath(32'h0002_2000, 1);
    issue(0, 0, 32'h0002_2000, 6'd0, 8'd0, 8'd0, 100000);
    repeat (3) @(negedge clk);
    reqUsePll = 1; reqCore = 1; reqValid = 1;
    @(negedge clk);
    reqValid = 0;
    finish(0, "divided + busy pulse R1");
    check(rCtrl[0] == 0 && rCtrl[3] == 1 && rCtrl[4] == 1 && rRef[8] == 0 && rRef[0] == 0, "R8",
          $sformatf("ctrl=%h ref=%h expected ctrl 18 set bit0 clear, ref off", rCtrl, rRef));
    repeat (20) @(negedge clk);
    check(!busy, "R1", $sformatf("busy after ignored pulse got %0d expected 0", busy));

    // core, PLL, delay grows: written before the switch
    rCtrl = 32'h8; rMem = 18; lockNeed = 0;
    expRd(A_MEM, 1, "R10");
    expWr(A_MEM, 32'hFFFFFFFF, dly(500000), 0, "R9");
    expPllPath(1, 32'h0, {10'b0, 6'd1, 8'd50, 8'd1}, 1, 0);
    issue(1, 1, 32'h0, 6'd1, 8'd50, 8'd1, 500000);
    finish(0, "core grow");
    check(rMem == 33, "R9", $sformatf("delay got %0d expected 33", rMem));

    // core, divided, delay shrinks: written after the switch
    rMem = 33;
    expRd(A_MEM, 1, "R10");
    expNpPath(32'h0, 1);
    expWr(A_MEM, 32'hFFFFFFFF, dly(300000), -1, "R10");
    issue(0, 1, 32'h0, 6'd0, 8'd0, 8'd0, 300000);
    finish(0, "core shrink");
    check(rMem == 20, "R10", $sformatf("delay got %0d expected 20", rMem));

    // core, equal delay: no write
    rMem = 20;
    expRd(A_MEM, 1, "R10");
    expNpPath(32'h0, 1);
    issue(0, 1, 32'h0, 6'd0, 8'd0, 8'd0, 300000);
    finish(0, "core equal");
    check(rMem == 20, "R10", $sformatf("delay got %0d expected 20", rMem));

    // core, low frequency: floor of 18
    rMem = 40;
    expRd(A_MEM, 1, "R10");
    expNpPath(32'h0, 1);
    expWr(A_MEM, 32'hFFFFFFFF, 32'd18, -1, "R9");
    issue(0, 1, 32'h0, 6'd0, 8'd0, 8'd0, 100000);
    finish(0, "core floor");
    check(rMem == 18, "R9", $sformatf("delay got %0d expected 18", rMem));

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL R11: watchdog got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

endmodule